// File: doc/BRIEF.md
# MSI Line Coherence Controller

This block keeps the coherence state of every line held by one private cache. Each line sits in one of three settled states (Invalid, Shared, Modified) or in one of three waiting states that a line passes through on its way up. The processor side offers one read or write request per cycle through a ready/valid handshake. Hits complete in the same cycle. Misses and upgrades send a bus read or a bus read-exclusive message, and the line then waits until a data message for it arrives.

The message side takes in one message per cycle from other caches: a remote read, a remote read-exclusive, or data. A holder answers remote reads and read-exclusives with a data message addressed to the sender, and then drops its own state. Several sharers may answer one request. The controller therefore acts on a data message only while the addressed line is waiting, and ignores every other copy. Waiting lines refuse new processor requests. This is what keeps two caches from ever holding one line Modified at the same moment.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `out_valid` and `done_valid` are low, and the first read of any line is a miss.
- R2: A read to a Shared or Modified line, or a write to a Modified line, is a hit. `req_ready` and `req_hit` are high in that cycle, and no message and no completion follow.
- R3: An accepted read to an Invalid line emits a bus read (`out_kind` 0, `out_dst` 0) for that line in the next cycle. A later data message for it makes the line Shared and pulses `done_valid` with `done_line` in the cycle after.
- R4: An accepted write to an Invalid line emits a bus read-exclusive (`out_kind` 1, `out_dst` 0) in the next cycle. The data message that follows makes the line Modified and pulses `done_valid`.
- R5: An accepted write to a Shared line emits a bus read-exclusive and waits. Its data message makes the line Modified and pulses `done_valid`.
- R6: `req_ready` is low while the requested line is waiting, and in any cycle in which `in_valid` is high.
- R7: A data message (`in_kind` 2) for a line that is not waiting changes no state and produces neither a message nor a completion.
- R8: A remote bus read (`in_kind` 0) to a Modified line emits a data message (`out_kind` 2) to `in_src` in the next cycle and leaves the line Shared.
- R9: A remote bus read-exclusive (`in_kind` 1) to a Modified or Shared line emits a data message to `in_src` and leaves the line Invalid.
- R10: A remote bus read to a Shared line emits a data message to `in_src`, and the line stays Shared.
- R11: A line waiting after a Shared-to-Modified upgrade that sees a remote read-exclusive answers with data and falls back to waiting as if from Invalid; its next data message makes it Modified. Lines waiting from Invalid ignore remote reads and read-exclusives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write (exclusive), 0 = read |
| req_line | input | LINE_W | Line id of the request |
| req_hit | output | 1 | Request completes this cycle without bus traffic |
| in_valid | input | 1 | Inbound message present |
| in_kind | input | 2 | 0 bus read, 1 bus read-exclusive, 2 data |
| in_line | input | LINE_W | Line id of the inbound message |
| in_src | input | NODE_W | Sender of the inbound message |
| out_valid | output | 1 | Outbound message present |
| out_kind | output | 2 | 0 bus read, 1 bus read-exclusive, 2 data |
| out_line | output | LINE_W | Line id of the outbound message |
| out_dst | output | NODE_W | Destination of a data reply, 0 otherwise |
| done_valid | output | 1 | A waiting line received its data |
| done_line | output | LINE_W | Line that completed |

## Verification
The bench builds the block with its defaults: sixteen lines, three-bit node ids, and sharer replies enabled. Sixteen lines let several lines sit in different states at once, so a message to one line can be shown to leave the others alone. With sharer replies on, a Shared holder answers remote reads and read-exclusives. That exposes the answering path both from the Shared state and from the Shared-to-Modified wait, including the race in which the upgrade loses to a remote read-exclusive. The three-bit id range lets each reply be checked against a distinct sender.

// File: rtl/msi_pkg.sv
package msi_pkg;

   typedef enum logic [2:0] {
      ST_I  = 3'd0,
      ST_S  = 3'd1,
      ST_M  = 3'd2,
      ST_IS = 3'd3,
      ST_IM = 3'd4,
      ST_SM = 3'd5
   } line_st_e;

   typedef enum logic [1:0] {
      MSG_RD   = 2'd0,
      MSG_RDX  = 2'd1,
      MSG_DATA = 2'd2
   } msg_e;

   typedef struct packed {
      logic     upd;
      line_st_e nxt;
      logic     emit;
      msg_e     kind;
      logic     done;
   } step_t;

   function automatic logic is_waiting(line_st_e s);
      return (s == ST_IS) || (s == ST_IM) || (s == ST_SM);
   endfunction

endpackage

// File: rtl/msi_state_table.sv
module msi_state_table
   import msi_pkg::*;
#(
   parameter int LINES  = 16,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] rd_a_idx,
   output line_st_e          rd_a_st,
   input  logic [LINE_W-1:0] rd_b_idx,
   output line_st_e          rd_b_st,
   input  logic              wr_en,
   input  logic [LINE_W-1:0] wr_idx,
   input  line_st_e          wr_st
);

   line_st_e st_q [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g] <= ST_I;
         end else if (wr_en && (wr_idx == LINE_W'(g))) begin
            st_q[g] <= wr_st;
         end
      end
   end

   assign rd_a_st = st_q[rd_a_idx];
   assign rd_b_st = st_q[rd_b_idx];

endmodule

// File: rtl/msi_req_step.sv
module msi_req_step
   import msi_pkg::*;
(
   input  line_st_e cur,
   input  logic     is_write,
   output logic     busy,
   output logic     hit,
   output step_t    act
);

   always_comb begin
      act      = '0;
      act.nxt  = cur;
      hit      = 1'b0;
      busy     = is_waiting(cur);
      unique case (cur)
         ST_I: begin
            act.upd  = 1'b1;
            act.emit = 1'b1;
            if (is_write) begin
               act.nxt  = ST_IM;
               act.kind = MSG_RDX;
            end else begin
               act.nxt  = ST_IS;
               act.kind = MSG_RD;
            end
         end
         ST_S: begin
            if (is_write) begin
               act.upd  = 1'b1;
               act.emit = 1'b1;
               act.nxt  = ST_SM;
               act.kind = MSG_RDX;
            end else begin
               hit = 1'b1;
            end
         end
         ST_M: hit = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/msi_snoop_step.sv
module msi_snoop_step
   import msi_pkg::*;
#(
   parameter bit SHARER_REPLY = 1'b1
) (
   input  line_st_e cur,
   input  msg_e     kind,
   output step_t    act
);

   logic s_reply;

   if (SHARER_REPLY) begin : g_all_answer
      assign s_reply = 1'b1;
   end else begin : g_owner_answers
      assign s_reply = 1'b0;
   end

   always_comb begin
      act      = '0;
      act.nxt  = cur;
      act.kind = MSG_DATA;
      unique case (kind)
         MSG_DATA: begin
            if (cur == ST_IS) begin
               act.upd  = 1'b1;
               act.nxt  = ST_S;
               act.done = 1'b1;
            end else if (cur == ST_IM || cur == ST_SM) begin
               act.upd  = 1'b1;
               act.nxt  = ST_M;
               act.done = 1'b1;
            end
         end
         MSG_RD: begin
            if (cur == ST_M) begin
               act.upd  = 1'b1;
               act.nxt  = ST_S;
               act.emit = 1'b1;
            end else if (cur == ST_S || cur == ST_SM) begin
               act.emit = s_reply;
            end
         end
         MSG_RDX: begin
            if (cur == ST_M) begin
               act.upd  = 1'b1;
               act.nxt  = ST_I;
               act.emit = 1'b1;
            end else if (cur == ST_S) begin
               act.upd  = 1'b1;
               act.nxt  = ST_I;
               act.emit = s_reply;
            end else if (cur == ST_SM) begin
               act.upd  = 1'b1;
               act.nxt  = ST_IM;
               act.emit = s_reply;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
   import msi_pkg::*;
#(
   parameter int LINES        = 16,
   parameter int NODE_W       = 3,
   parameter bit SHARER_REPLY = 1'b1,
   localparam int LINE_W      = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [LINE_W-1:0] req_line,
   output logic              req_hit,
   input  logic              in_valid,
   input  logic [1:0]        in_kind,
   input  logic [LINE_W-1:0] in_line,
   input  logic [NODE_W-1:0] in_src,
   output logic              out_valid,
   output logic [1:0]        out_kind,
   output logic [LINE_W-1:0] out_line,
   output logic [NODE_W-1:0] out_dst,
   output logic              done_valid,
   output logic [LINE_W-1:0] done_line
);

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (NODE_W < 1) begin : g_bad_node
      $error("NODE_W must be at least 1");
   end

   line_st_e          req_st, in_st;
   logic              req_busy, req_hit_raw;
   step_t             req_act, sn_act, act;
   logic [LINE_W-1:0] act_line;

   msi_state_table #(.LINES(LINES)) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (req_line),
      .rd_a_st  (req_st),
      .rd_b_idx (in_line),
      .rd_b_st  (in_st),
      .wr_en    (act.upd),
      .wr_idx   (act_line),
      .wr_st    (act.nxt)
   );

   msi_req_step i_req (
      .cur      (req_st),
      .is_write (req_write),
      .busy     (req_busy),
      .hit      (req_hit_raw),
      .act      (req_act)
   );

   msi_snoop_step #(.SHARER_REPLY(SHARER_REPLY)) i_snoop (
      .cur  (in_st),
      .kind (msg_e'(in_kind)),
      .act  (sn_act)
   );

   assign req_ready = !in_valid && !req_busy;
   assign req_hit   = req_ready && req_hit_raw;

   always_comb begin
      if (in_valid) begin
         act      = sn_act;
         act_line = in_line;
      end else if (req_valid && req_ready) begin
         act      = req_act;
         act_line = req_line;
      end else begin
         act      = '0;
         act_line = req_line;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_kind   <= 2'd0;
         out_line   <= '0;
         out_dst    <= '0;
         done_valid <= 1'b0;
         done_line  <= '0;
      end else begin
         out_valid  <= act.emit;
         out_kind   <= act.kind;
         out_line   <= act_line;
         out_dst    <= (act.emit && act.kind == MSG_DATA) ? in_src : '0;
         done_valid <= act.done;
         done_line  <= act_line;
      end
   end

   assert_done_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> ($past(in_valid) && $past(in_kind) == 2'd2 && $past(in_line) == done_line));

   assert_miss_emits_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_hit) |=>
         (out_valid && out_kind != 2'd2 && out_line == $past(req_line) && out_dst == '0));

   assert_hit_is_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_hit) |=> (!out_valid && !done_valid));

   assert_reply_to_sender_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 2'd2) |->
         ($past(in_valid) && $past(in_kind) != 2'd2 && out_dst == $past(in_src)));

   assert_waiting_line_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_hit) |=>
         !(req_valid && req_ready && req_line == $past(req_line)));

   assert_no_reply_on_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind == 2'd2) |=> !out_valid);

endmodule

// File: tb/test_msi_line_ctrl.sv
module test_msi_line_ctrl;

   localparam int LINES  = 16;
   localparam int NODE_W = 3;
   localparam int LW     = $clog2(LINES);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [LW-1:0] req_line = '0;
   logic req_ready, req_hit;
   logic in_valid = 1'b0;
   logic [1:0] in_kind = 2'd0;
   logic [LW-1:0] in_line = '0;
   logic [NODE_W-1:0] in_src = '0;
   logic out_valid, done_valid;
   logic [1:0] out_kind;
   logic [LW-1:0] out_line, done_line;
   logic [NODE_W-1:0] out_dst;

   int checks = 0;
   int fails  = 0;
   int mst [LINES];   // 0 I, 1 S, 2 M, 3 wait-from-I-read, 4 wait-from-I-write, 5 wait-from-S-write

   always #5 clk = ~clk;

   msi_line_ctrl #(.LINES(LINES), .NODE_W(NODE_W), .SHARER_REPLY(1'b1)) i_msi_line_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_line(req_line), .req_hit(req_hit),
      .in_valid(in_valid), .in_kind(in_kind), .in_line(in_line), .in_src(in_src),
      .out_valid(out_valid), .out_kind(out_kind), .out_line(out_line), .out_dst(out_dst),
      .done_valid(done_valid), .done_line(done_line)
   );

   task automatic step(input string tag, input bit rv, input bit rw, input int rl,
                       input bit iv, input int ik, input int il, input int isrc);
      int st, s;
      bit e_ready, e_hit, e_ov, e_dv;
      int e_ok, e_ol, e_od, e_dl;
      req_valid = rv; req_write = rw; req_line = LW'(rl);
      in_valid = iv; in_kind = 2'(ik); in_line = LW'(il); in_src = NODE_W'(isrc);
      #1;
      st = mst[rl];
      e_ready = !iv && (st < 3);
      e_hit = e_ready && ((!rw && (st == 1 || st == 2)) || (rw && st == 2));
      e_ov = 0; e_ok = 0; e_ol = 0; e_od = 0; e_dv = 0; e_dl = 0;
      if (iv) begin
         s = mst[il];
         if (ik == 2) begin
            if (s == 3) begin mst[il] = 1; e_dv = 1; e_dl = il; end
            else if (s == 4 || s == 5) begin mst[il] = 2; e_dv = 1; e_dl = il; end
         end else if (ik == 0) begin
            if (s == 2) mst[il] = 1;
            if (s == 1 || s == 2 || s == 5) begin e_ov = 1; e_ok = 2; e_ol = il; e_od = isrc; end
         end else if (ik == 1) begin
            if (s == 1 || s == 2) mst[il] = 0;
            if (s == 5) mst[il] = 4;
            if (s == 1 || s == 2 || s == 5) begin e_ov = 1; e_ok = 2; e_ol = il; e_od = isrc; end
         end
      end else if (rv && e_ready && !e_hit) begin
         e_ov = 1; e_ol = rl; e_od = 0;
         if (st == 0) begin mst[rl] = rw ? 4 : 3; e_ok = rw ? 1 : 0; end
         else begin mst[rl] = 5; e_ok = 1; end
      end
      checks++;
      if (req_ready !== e_ready || req_hit !== e_hit) begin
         fails++;
         $display("FAIL %s ready/hit actual %b/%b expected %b/%b", tag, req_ready, req_hit, e_ready, e_hit);
      end
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (out_valid !== e_ov || done_valid !== e_dv ||
          (e_ov && (out_kind !== 2'(e_ok) || out_line !== LW'(e_ol) || out_dst !== NODE_W'(e_od))) ||
          (e_dv && done_line !== LW'(e_dl))) begin
         fails++;
         $display("FAIL %s out v%b k%0d l%0d d%0d done v%b l%0d expected out v%b k%0d l%0d d%0d done v%b l%0d",
                  tag, out_valid, out_kind, out_line, out_dst, done_valid, done_line,
                  e_ov, e_ok, e_ol, e_od, e_dv, e_dl);
      end
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      for (int i = 0; i < LINES; i++) mst[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      checks++;
      if (out_valid !== 1'b0 || done_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset outputs actual %b/%b expected 0/0", out_valid, done_valid);
      end
      // R1 / R3: first read misses, then fill
      step("R1", 1, 0, 3, 0, 0, 0, 0);
      step("R6", 1, 0, 3, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 1, 2, 3, 5);
      step("R7", 0, 0, 0, 1, 2, 3, 6);
      step("R2", 1, 0, 3, 0, 0, 0, 0);
      // R4: write miss
      step("R4", 1, 1, 5, 0, 0, 0, 0);
      step("R4", 0, 0, 0, 1, 2, 5, 1);
      step("R2", 1, 1, 5, 0, 0, 0, 0);
      step("R2", 1, 0, 5, 0, 0, 0, 0);
      // R5: upgrade from Shared, with a request stalled by inbound traffic
      step("R5", 1, 1, 3, 0, 0, 0, 0);
      step("R6", 1, 1, 3, 0, 0, 0, 0);
      step("R6", 1, 0, 9, 1, 2, 3, 2);
      step("R5", 1, 1, 3, 0, 0, 0, 0);
      // R8: remote read to Modified
      step("R8", 0, 0, 0, 1, 0, 5, 2);
      step("R8", 1, 1, 5, 0, 0, 0, 0);
      step("R8", 0, 0, 0, 1, 2, 5, 3);
      // R9: remote read-exclusive to Modified, then to Shared
      step("R9", 0, 0, 0, 1, 1, 3, 1);
      step("R9", 1, 0, 3, 0, 0, 0, 0);
      step("R9", 0, 0, 0, 1, 2, 3, 4);
      step("R10", 0, 0, 0, 1, 0, 3, 4);
      step("R10", 1, 0, 3, 0, 0, 0, 0);
      step("R9", 0, 0, 0, 1, 1, 3, 7);
      step("R9", 1, 0, 3, 0, 0, 0, 0);
      step("R9", 0, 0, 0, 1, 2, 3, 2);
      // R11: upgrade loses to remote read-exclusive
      step("R11", 1, 1, 3, 0, 0, 0, 0);
      step("R11", 0, 0, 0, 1, 1, 3, 6);
      step("R11", 1, 0, 3, 0, 0, 0, 0);
      step("R11", 0, 0, 0, 1, 2, 3, 6);
      step("R11", 0, 0, 0, 1, 2, 3, 5);
      step("R11", 1, 1, 3, 0, 0, 0, 0);
      // R11: wait-from-Invalid ignores remote requests
      step("R11", 1, 0, 7, 0, 0, 0, 0);
      step("R11", 0, 0, 0, 1, 0, 7, 3);
      step("R11", 0, 0, 0, 1, 1, 7, 3);
      step("R11", 0, 0, 0, 1, 2, 7, 3);
      step("R11", 1, 0, 7, 0, 0, 0, 0);
      // R7: stray data to an Invalid line
      step("R7", 0, 0, 0, 1, 2, 9, 1);
      step("R7", 1, 0, 9, 0, 0, 0, 0);
      step("R7", 0, 0, 0, 1, 2, 9, 1);
      step("R7", 0, 0, 0, 0, 0, 0, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule